// File: doc/BRIEF.md
# Byte and Pair Register Bank for an 8-bit Processor

This block holds the architectural state of a small 8-bit processor core: seven general byte registers (A, B, C, D, E, H, L), a flag byte F, and two true 16-bit registers for the stack pointer (SP) and program counter (PC). Surrounding logic, such as the decoder, ALU, and fetch unit, reads and writes it through two independent port sets. A byte port is addressed by a register index. A 16-bit port is addressed by a pair index, which either joins two byte registers into one word or selects SP or PC whole.

Both read ports are combinational, so the selected value appears in the same cycle that the select changes. Writes take effect on the rising clock edge. The flag byte keeps only its four defined flag bits: zero, subtract, half-carry and carry. Its lower nibble always reads as zero. When both write ports touch the same byte in one cycle, the 16-bit port wins on that byte.

Top module: `byte_pair_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every byte register, SP and PC to zero at the clock edge where it is sampled high. Any write requested in that cycle is discarded.
- R2: Byte register indices are A=0, B=1, C=2, D=3, E=4, H=5, L=6, F=7. A byte write with `wr8_en` high stores `wr8_data` into the indexed register. The value is visible on `rd8_data` from the cycle after that edge.
- R3: Pair indices are AF=0, BC=1, DE=2, HL=3, SP=4, PC=5. For pairs 0 to 3, `rd16_data[15:8]` is the first-named register and `rd16_data[7:0]` is the second-named register.
- R4: A 16-bit write with `wr16_en` high to pairs 0 to 3 stores `wr16_data[15:8]` into the first-named register and `wr16_data[7:0]` into the second-named register. Both bytes are readable on the byte port in the next cycle.
- R5: A 16-bit write to pair 4 or 5 replaces SP or PC whole. SP and PC share no storage with the byte registers.
- R6: F holds zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Writes to F, whether direct or through AF, keep bits 7 to 4 only. Bits 3 to 0 of F always read as zero on both read ports.
- R7: If both write ports target the same byte register in one cycle, that register takes the 16-bit port's byte. A byte write to a register outside the 16-bit target still takes effect in the same cycle.
- R8: Pair indices 6 and 7 read as zero. A 16-bit write to either of them changes no register.
- R9: Reads are combinational. Changing `rd8_sel` or `rd16_sel` without a clock edge presents the newly selected register at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd8_sel | input | 3 | Byte read register index |
| rd8_data | output | 8 | Byte read data |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Byte write register index |
| wr8_data | input | 8 | Byte write data |
| rd16_sel | input | 3 | Pair read index |
| rd16_data | output | 16 | Pair read data |
| wr16_en | input | 1 | Pair write enable |
| wr16_sel | input | 3 | Pair write index |
| wr16_data | input | 16 | Pair write data |

## Verification
The hardest case to reach from the ports is a collision: both write ports land on the same byte register in one cycle, and the result must then be read through the other port. Random stimulus alone reaches this only now and then. The bench therefore adds directed cycles that pair a byte write with a 16-bit write covering the same register, one covering the other half of the pair, and one aimed at the F half of AF. After each edge it sweeps every byte index and every pair index, so the winning value and the masked flag nibble are both observed.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

    localparam int NUM_REGS  = 8;
    localparam int SEL_W     = 3;
    localparam int NUM_FLAGS = 4;

    typedef enum logic [SEL_W-1:0] {
        RI_A = 3'd0,
        RI_B = 3'd1,
        RI_C = 3'd2,
        RI_D = 3'd3,
        RI_E = 3'd4,
        RI_H = 3'd5,
        RI_L = 3'd6,
        RI_F = 3'd7
    } reg_idx_e;

    typedef enum logic [SEL_W-1:0] {
        PI_AF  = 3'd0,
        PI_BC  = 3'd1,
        PI_DE  = 3'd2,
        PI_HL  = 3'd3,
        PI_SP  = 3'd4,
        PI_PC  = 3'd5,
        PI_NO6 = 3'd6,
        PI_NO7 = 3'd7
    } pair_idx_e;

    // True when the pair index joins two byte registers
    function automatic logic pair_is_bytes(input logic [SEL_W-1:0] p);
        return (p <= SEL_W'(PI_HL));
    endfunction

    // Register index that forms the upper byte of a byte pair
    function automatic logic [SEL_W-1:0] pair_hi(input logic [SEL_W-1:0] p);
        case (pair_idx_e'(p))
            PI_AF:   return RI_A;
            PI_BC:   return RI_B;
            PI_DE:   return RI_D;
            default: return RI_H;
        endcase
    endfunction

    // Register index that forms the lower byte of a byte pair
    function automatic logic [SEL_W-1:0] pair_lo(input logic [SEL_W-1:0] p);
        case (pair_idx_e'(p))
            PI_AF:   return RI_F;
            PI_BC:   return RI_C;
            PI_DE:   return RI_E;
            default: return RI_L;
        endcase
    endfunction

    // Steered write request for one storage cell
    typedef struct packed {
        logic       en;
        logic [7:0] data;
    } byte_wr_t;

endpackage

// File: rtl/bpr_wr_steer.sv
module bpr_wr_steer
    import bpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                           wr8_en,
    input  logic [SEL_W-1:0]               wr8_sel,
    input  logic [DATA_W-1:0]              wr8_data,
    input  logic                           wr16_en,
    input  logic [SEL_W-1:0]               wr16_sel,
    input  logic [2*DATA_W-1:0]            wr16_data,
    output logic [NUM_REGS-1:0]            byte_we,
    output logic [NUM_REGS-1:0][DATA_W-1:0] byte_wd,
    output logic                           sp_we,
    output logic                           pc_we
);

    localparam int WIDE_W = 2 * DATA_W;

    logic pair_hit;
    assign pair_hit = wr16_en && pair_is_bytes(wr16_sel);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_lane
        logic              we_i;
        logic [DATA_W-1:0] wd_i;
        // The 16-bit port has priority over the byte port on shared bytes
        always_comb begin
            we_i = 1'b0;
            wd_i = '0;
            if (pair_hit && (pair_hi(wr16_sel) == SEL_W'(i))) begin
                we_i = 1'b1;
                wd_i = wr16_data[WIDE_W-1:DATA_W];
            end else if (pair_hit && (pair_lo(wr16_sel) == SEL_W'(i))) begin
                we_i = 1'b1;
                wd_i = wr16_data[DATA_W-1:0];
            end else if (wr8_en && (wr8_sel == SEL_W'(i))) begin
                we_i = 1'b1;
                wd_i = wr8_data;
            end
        end
        assign byte_we[i] = we_i;
        assign byte_wd[i] = wd_i;
    end

    assign sp_we = wr16_en && (wr16_sel == SEL_W'(PI_SP));
    assign pc_we = wr16_en && (wr16_sel == SEL_W'(PI_PC));

endmodule

// File: rtl/bpr_byte_cell.sv
module bpr_byte_cell #(
    parameter int DATA_W   = 8,
    parameter int KEEP_LSB = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] q
);

    if (KEEP_LSB == 0) begin : g_full
        logic [DATA_W-1:0] store;
        always_ff @(posedge clk) begin
            if (rst)     store <= '0;
            else if (we) store <= wd;
        end
        assign q = store;
    end else begin : g_part
        // Only the upper bits are stored; the rest read back as zero
        logic [DATA_W-1:KEEP_LSB] store;
        always_ff @(posedge clk) begin
            if (rst)     store <= '0;
            else if (we) store <= wd[DATA_W-1:KEEP_LSB];
        end
        assign q = {store, {KEEP_LSB{1'b0}}};
    end

endmodule

// File: rtl/bpr_wide_cell.sv
module bpr_wide_cell #(
    parameter int WIDE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WIDE_W-1:0] wd,
    output logic [WIDE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wd;
    end

endmodule

// File: rtl/byte_pair_regfile.sv
module byte_pair_regfile
    import bpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          rd8_sel,
    output logic [DATA_W-1:0]   rd8_data,
    input  logic                wr8_en,
    input  logic [2:0]          wr8_sel,
    input  logic [DATA_W-1:0]   wr8_data,
    input  logic [2:0]          rd16_sel,
    output logic [2*DATA_W-1:0] rd16_data,
    input  logic                wr16_en,
    input  logic [2:0]          wr16_sel,
    input  logic [2*DATA_W-1:0] wr16_data
);

    localparam int WIDE_W   = 2 * DATA_W;
    localparam int FLAG_LSB = DATA_W - NUM_FLAGS;

    logic [NUM_REGS-1:0]             byte_we;
    logic [NUM_REGS-1:0][DATA_W-1:0] byte_wd;
    logic [NUM_REGS-1:0][DATA_W-1:0] byte_q;
    logic                            sp_we;
    logic                            pc_we;
    logic [WIDE_W-1:0]               sp_q;
    logic [WIDE_W-1:0]               pc_q;

    bpr_wr_steer #(.DATA_W(DATA_W)) u_steer (
        .wr8_en    (wr8_en),
        .wr8_sel   (wr8_sel),
        .wr8_data  (wr8_data),
        .wr16_en   (wr16_en),
        .wr16_sel  (wr16_sel),
        .wr16_data (wr16_data),
        .byte_we   (byte_we),
        .byte_wd   (byte_wd),
        .sp_we     (sp_we),
        .pc_we     (pc_we)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // The flag byte keeps only its upper flag bits
        bpr_byte_cell #(
            .DATA_W   (DATA_W),
            .KEEP_LSB ((i == int'(RI_F)) ? FLAG_LSB : 0)
        ) u_cell (
            .clk (clk),
            .rst (rst),
            .we  (byte_we[i]),
            .wd  (byte_wd[i]),
            .q   (byte_q[i])
        );
    end

    bpr_wide_cell #(.WIDE_W(WIDE_W)) u_sp (
        .clk (clk), .rst (rst), .we (sp_we), .wd (wr16_data), .q (sp_q)
    );

    bpr_wide_cell #(.WIDE_W(WIDE_W)) u_pc (
        .clk (clk), .rst (rst), .we (pc_we), .wd (wr16_data), .q (pc_q)
    );

    assign rd8_data = byte_q[rd8_sel];

    always_comb begin
        case (pair_idx_e'(rd16_sel))
            PI_AF, PI_BC, PI_DE, PI_HL:
                rd16_data = {byte_q[pair_hi(rd16_sel)], byte_q[pair_lo(rd16_sel)]};
            PI_SP:   rd16_data = sp_q;
            PI_PC:   rd16_data = pc_q;
            default: rd16_data = '0;
        endcase
    end

endmodule

// File: rtl/byte_pair_regfile_chk.sv
module byte_pair_regfile_chk
    import bpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          rd8_sel,
    input logic [DATA_W-1:0]   rd8_data,
    input logic                wr8_en,
    input logic [2:0]          wr8_sel,
    input logic [DATA_W-1:0]   wr8_data,
    input logic [2:0]          rd16_sel,
    input logic [2*DATA_W-1:0] rd16_data,
    input logic                wr16_en,
    input logic [2:0]          wr16_sel,
    input logic [2*DATA_W-1:0] wr16_data
);

    localparam int FLAG_LSB = DATA_W - NUM_FLAGS;
    localparam int WIDE_W   = 2 * DATA_W;

    logic covered8;
    assign covered8 = wr16_en && pair_is_bytes(wr16_sel) &&
                      ((pair_hi(wr16_sel) == wr8_sel) || (pair_lo(wr16_sel) == wr8_sel));

    AST_RESET_CLEARS: assert property (@(posedge clk)
        ($past(rst) === 1'b1) && !rst |-> (rd8_data == '0) && (rd16_data == '0)); // R1

    AST_BYTE_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        wr8_en && !covered8 && (wr8_sel != SEL_W'(RI_F))
        |=> (rd8_sel != $past(wr8_sel)) || (rd8_data == $past(wr8_data))); // R2

    AST_PAIR_HIGH_BYTE: assert property (@(posedge clk) disable iff (rst)
        pair_is_bytes(rd16_sel) && (rd8_sel == pair_hi(rd16_sel))
        |-> rd16_data[WIDE_W-1:DATA_W] == rd8_data); // R3

    AST_PAIR_WRITE_HIGH: assert property (@(posedge clk) disable iff (rst)
        wr16_en && pair_is_bytes(wr16_sel)
        |=> (rd8_sel != pair_hi($past(wr16_sel))) ||
            (rd8_data == $past(wr16_data[WIDE_W-1:DATA_W]))); // R4 R7

    AST_WIDE_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        wr16_en && !pair_is_bytes(wr16_sel) && (wr16_sel <= SEL_W'(PI_PC))
        |=> (rd16_sel != $past(wr16_sel)) || (rd16_data == $past(wr16_data))); // R5

    AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd8_sel == SEL_W'(RI_F)) |-> (rd8_data[FLAG_LSB-1:0] == '0)); // R6

    AST_FLAG_WRITE_MASK: assert property (@(posedge clk) disable iff (rst)
        wr8_en && !covered8 && (wr8_sel == SEL_W'(RI_F))
        |=> (rd8_sel != SEL_W'(RI_F)) ||
            (rd8_data == {$past(wr8_data[DATA_W-1:FLAG_LSB]), {FLAG_LSB{1'b0}}})); // R6

    AST_SPARE_PAIR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd16_sel > SEL_W'(PI_PC)) |-> (rd16_data == '0)); // R8

endmodule

bind byte_pair_regfile byte_pair_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_byte_pair_regfile.sv
`timescale 1ns/100ps
module sim_byte_pair_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd8_sel;
    logic [7:0]  rd8_data;
    logic        wr8_en;
    logic [2:0]  wr8_sel;
    logic [7:0]  wr8_data;
    logic [2:0]  rd16_sel;
    logic [15:0] rd16_data;
    logic        wr16_en;
    logic [2:0]  wr16_sel;
    logic [15:0] wr16_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  m8 [8];
    logic [15:0] msp;
    logic [15:0] mpc;

    always #5 clk = ~clk;

    byte_pair_regfile u0 (.*);

    function automatic int hi_of(int p);
        case (p)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int lo_of(int p);
        case (p)
            0: return 7;
            1: return 2;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    function automatic logic [7:0] keep(int idx, logic [7:0] v);
        return (idx == 7) ? (v & 8'hF0) : v;
    endfunction

    function automatic logic [15:0] exp16(int p);
        if (p < 4) return {m8[hi_of(p)], m8[lo_of(p)]};
        if (p == 4) return msp;
        if (p == 5) return mpc;
        return 16'h0000;
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Sweep every byte and pair index without a clock edge (R9 path)
    task automatic sweep(string ctx);
        for (int i = 0; i < 8; i++) begin
            rd8_sel  = 3'(i);
            rd16_sel = 3'(i);
            #0.4;
            chk($sformatf("%s %s byte%0d", ctx, (i == 7) ? "R6" : "R2", i),
                {8'h00, rd8_data}, {8'h00, m8[i]});
            chk($sformatf("%s %s pair%0d", ctx,
                          (i < 4) ? "R3" : ((i < 6) ? "R5" : "R8"), i),
                rd16_data, exp16(i));
        end
    endtask

    // Drive one cycle of writes, update the model at the edge
    task automatic cyc(bit r, bit e8, int s8, logic [7:0] d8,
                       bit e16, int s16, logic [15:0] d16);
        rst = r; wr8_en = e8; wr8_sel = 3'(s8); wr8_data = d8;
        wr16_en = e16; wr16_sel = 3'(s16); wr16_data = d16;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 8; i++) m8[i] = 8'h00;
            msp = 16'h0; mpc = 16'h0;
        end else begin
            if (e8) m8[s8] = keep(s8, d8);
            if (e16 && s16 < 4) begin
                m8[hi_of(s16)] = keep(hi_of(s16), d16[15:8]);
                m8[lo_of(s16)] = keep(lo_of(s16), d16[7:0]);
            end
            if (e16 && s16 == 4) msp = d16;
            if (e16 && s16 == 5) mpc = d16;
        end
        @(negedge clk);
        wr8_en = 1'b0; wr16_en = 1'b0; rst = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rd8_sel = 3'd0; rd16_sel = 3'd0;
        for (int i = 0; i < 8; i++) m8[i] = 8'hxx;
        msp = 16'hxxxx; mpc = 16'hxxxx;
        @(negedge clk);
        // R1: reset with writes requested still clears everything
        cyc(1, 1, 1, 8'h55, 1, 4, 16'hBEEF);
        cyc(1, 1, 0, 8'hAA, 1, 2, 16'h1234);
        sweep("R1 reset");

        // R2: plain byte writes to each register
        for (int i = 0; i < 8; i++) cyc(0, 1, i, 8'(8'h11 * (i + 1)), 0, 0, 16'h0);
        sweep("R2 bytes");

        // R4: pair write splits into two bytes
        cyc(0, 0, 0, 8'h00, 1, 1, 16'h1234);
        rd8_sel = 3'd1; #0.4; chk("R4 B from BC", {8'h0, rd8_data}, 16'h0012);
        rd8_sel = 3'd2; #0.4; chk("R4 C from BC", {8'h0, rd8_data}, 16'h0034);

        // R6: AF write masks the flag nibble
        cyc(0, 0, 0, 8'h00, 1, 0, 16'h9ABF);
        rd16_sel = 3'd0; #0.4; chk("R6 AF low nibble", rd16_data, 16'h9AB0);
        cyc(0, 1, 7, 8'h5F, 0, 0, 16'h0);
        rd8_sel = 3'd7; #0.4; chk("R6 F direct", {8'h0, rd8_data}, 16'h0050);

        // R5: SP and PC whole, byte registers untouched
        cyc(0, 0, 0, 8'h00, 1, 4, 16'hFFFE);
        cyc(0, 0, 0, 8'h00, 1, 5, 16'h0150);
        sweep("R5 wide");

        // R7: collisions between the two write ports
        cyc(0, 1, 3, 8'hAA, 1, 2, 16'h7788);
        rd8_sel = 3'd3; #0.4; chk("R7 D 16-bit wins", {8'h0, rd8_data}, 16'h0077);
        cyc(0, 1, 6, 8'hCC, 1, 2, 16'h3344);
        rd8_sel = 3'd6; #0.4; chk("R7 L outside pair", {8'h0, rd8_data}, 16'h00CC);
        cyc(0, 1, 7, 8'hF0, 1, 0, 16'h0120);
        rd8_sel = 3'd7; #0.4; chk("R7 F from AF wins", {8'h0, rd8_data}, 16'h0020);
        sweep("R7 collide");

        // R8: spare pair codes write nothing
        cyc(0, 0, 0, 8'h00, 1, 6, 16'hDEAD);
        cyc(0, 0, 0, 8'h00, 1, 7, 16'hFACE);
        sweep("R8 spare");

        // R9: select change with no clock edge
        rd16_sel = 3'd4; #0.4; chk("R9 comb SP", rd16_data, msp);
        rd16_sel = 3'd5; #0.4; chk("R9 comb PC", rd16_data, mpc);

        // Constrained random mix with frequent collisions
        for (int n = 0; n < 400; n++) begin
            int s8, s16;
            s16 = $urandom_range(0, 7);
            s8  = ($urandom_range(0, 3) == 0 && s16 < 4) ?
                  (($urandom_range(0, 1) == 1) ? hi_of(s16) : lo_of(s16)) :
                  $urandom_range(0, 7);
            cyc(($urandom_range(0, 63) == 0), 1'($urandom_range(0, 1)), s8,
                8'($urandom), 1'($urandom_range(0, 1)), s16, 16'($urandom));
            sweep("rand");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 got=hung exp=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule